// File: doc/BRIEF.md
# Sequential Single-Precision Float Divider

This block divides one 32-bit IEEE 754 single-precision value by another over several clock cycles. A caller presents the dividend and divisor together with a one-cycle `start` pulse. While the block works, `busy` is high. When the quotient is ready, `done` pulses for one cycle and the 32-bit result appears on `quotient`. That result stays on `quotient` until the next division completes.

Both significands get their hidden leading one back. They are then divided by restoring long division, which retires `STEP` quotient bits per clock. The block produces 26 significant quotient bits: 24 for the result significand and one guard bit, plus the one bit that normalization may consume. All bits below the kept fraction are truncated. The exponent is the biased difference of the operand exponents, and the sign is the XOR of the operand signs. Special operands take a fixed priority path, and their results arrive with the same timing as ordinary results.

Top module: `fdiv_seq`

## Requirements
- R1: The sign bit of a finite nonzero result, of an infinite result and of a zero result is the XOR of the sign bits (bit 31) of the two operands.
- R2: For normal operands, the result exponent field is the dividend exponent field minus the divisor exponent field plus 127. One more is subtracted when the dividend significand (1.f) is smaller than the divisor significand, in which case the quotient is shifted left by one place.
- R3: The 23-bit result fraction is the normalized significand quotient truncated toward zero, with no rounding.
- R4: `done` rises at the ceil(26/STEP)-th rising clock edge after the edge that accepts `start` and lasts one cycle. `busy` is high from the accepting edge until that same edge.
- R5: A `start` that arrives while `busy` is high is ignored, and the running division finishes with its original operands and timing.
- R6: The result is the quiet NaN 32'h7FC00000 if either operand is a NaN (exponent field 255, fraction nonzero) or if the divisor is zero. This case has the highest priority.
- R7: Otherwise, an infinite dividend (exponent field 255, fraction zero) gives infinity, even when the divisor is also infinite.
- R8: Otherwise, an infinite divisor gives zero.
- R9: Otherwise, a zero dividend gives zero. An operand with exponent field 0 counts as zero, whatever its fraction bits hold.
- R10: A normal-path result exponent below 1 gives zero.
- R11: A normal-path result exponent above 254 gives infinity.
- R12: After reset, `quotient`, `busy` and `done` are 0. `quotient` changes only in a cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division with the present operands |
| dividend | input | 32 | Dividend, single precision |
| divisor | input | 32 | Divisor, single precision |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion strobe |
| quotient | output | 32 | Result, held until the next completion |

## Verification
The bench builds the divider with `STEP` = 3. Because 26 is not a multiple of 3, the iteration yields 27 quotient bits and the lowest one has to be dropped correctly. The latency becomes nine cycles, which leaves a wide window for a second `start` to land while the block is busy. Exponent boundaries are reached with operands whose result exponent sits exactly at 1 and 254, and just outside them, both with and without the normalization shift.

// File: rtl/fdiv_seq.sv
module fdiv_seq #(
  parameter int STEP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] dividend,
  input  logic [31:0] divisor,
  output logic        busy,
  output logic        done,
  output logic [31:0] quotient
);
  localparam int QBITS = 26;
  localparam int ITER  = (QBITS + STEP - 1) / STEP;
  localparam int QW    = ITER * STEP;
  localparam int CW    = $clog2(ITER + 1);

  localparam logic [1:0] SP_NONE = 2'd0, SP_NAN = 2'd1, SP_INF = 2'd2, SP_ZERO = 2'd3;

  logic              busy_q, done_q;
  logic [31:0]       res_q;
  logic [24:0]       rem_q, rem_n;
  logic [QW-1:0]     quo_q, quo_n;
  logic [23:0]       mb_q;
  logic              sgn_q;
  logic signed [9:0] exp_q;
  logic [1:0]        spec_q, spec_in;
  logic [CW-1:0]     cnt_q;

  wire a_max  = &dividend[30:23];
  wire b_max  = &divisor[30:23];
  wire a_nan  = a_max & (|dividend[22:0]);
  wire b_nan  = b_max & (|divisor[22:0]);
  wire a_inf  = a_max & ~(|dividend[22:0]);
  wire b_inf  = b_max & ~(|divisor[22:0]);
  wire a_zero = ~(|dividend[30:23]);
  wire b_zero = ~(|divisor[30:23]);

  always_comb begin
    if (a_nan || b_nan || b_zero) spec_in = SP_NAN;
    else if (a_inf)               spec_in = SP_INF;
    else if (b_inf)               spec_in = SP_ZERO;
    else if (a_zero)              spec_in = SP_ZERO;
    else                          spec_in = SP_NONE;
  end

  wire [9:0] exp_in = {2'b00, dividend[30:23]} - {2'b00, divisor[30:23]} + 10'd127;

  always_comb begin
    logic [24:0]   r;
    logic [QW-1:0] q;
    logic          qb;
    r = rem_q;
    q = quo_q;
    for (int i = 0; i < STEP; i++) begin
      qb = (r >= {1'b0, mb_q});
      if (qb) r = r - {1'b0, mb_q};
      r = {r[23:0], 1'b0};
      q = {q[QW-2:0], qb};
    end
    rem_n = r;
    quo_n = q;
  end

  wire [QBITS-1:0]    q26  = quo_n[QW-1 -: QBITS];
  wire                norm = q26[QBITS-1];
  wire [22:0]         frac = norm ? q26[24:2] : q26[23:1];
  wire signed [9:0]   e_fin = exp_q - (norm ? 10'sd0 : 10'sd1);
  logic [31:0]        res_n;

  always_comb begin
    case (spec_q)
      SP_NAN:  res_n = 32'h7FC0_0000;
      SP_INF:  res_n = {sgn_q, 8'hFF, 23'd0};
      SP_ZERO: res_n = {sgn_q, 31'd0};
      default: begin
        if (e_fin < 10'sd1)        res_n = {sgn_q, 31'd0};
        else if (e_fin > 10'sd254) res_n = {sgn_q, 8'hFF, 23'd0};
        else                       res_n = {sgn_q, e_fin[7:0], frac};
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      res_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      mb_q   <= '0;
      sgn_q  <= 1'b0;
      exp_q  <= '0;
      spec_q <= SP_NONE;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        rem_q  <= {2'b01, dividend[22:0]};
        mb_q   <= {1'b1, divisor[22:0]};
        quo_q  <= '0;
        sgn_q  <= dividend[31] ^ divisor[31];
        exp_q  <= $signed(exp_in);
        spec_q <= spec_in;
        cnt_q  <= CW'(ITER);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= rem_n;
        quo_q <= quo_n;
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          res_q  <= res_n;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign quotient = res_q;
endmodule

// File: rtl/fdiv_seq_chk.sv
module fdiv_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [31:0] quotient
);
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_start_sets_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_busy_end_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_done_not_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_busy_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !$fell(busy)) |-> !done);
  assert_result_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(quotient));
endmodule

bind fdiv_seq fdiv_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .quotient(quotient)
);

// File: tb/fdiv_seq_tb_top.sv
module fdiv_seq_tb_top;
  localparam int STEP = 3;
  localparam int LAT  = (26 + STEP - 1) / STEP;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] dividend = '0, divisor = '0;
  logic        busy, done;
  logic [31:0] quotient;
  int          n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  fdiv_seq #(.STEP(STEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .quotient(quotient)
  );

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b);
    logic s;
    logic [63:0] q;
    int e;
    s = a[31] ^ b[31];
    if ((a[30:23] == 8'hFF && a[22:0] != 0) || (b[30:23] == 8'hFF && b[22:0] != 0) || b[30:23] == 0)
      return 32'h7FC0_0000;
    if (a[30:23] == 8'hFF) return {s, 8'hFF, 23'd0};
    if (b[30:23] == 8'hFF) return {s, 31'd0};
    if (a[30:23] == 0)     return {s, 31'd0};
    q = ({40'd0, 1'b1, a[22:0]} << 25) / {40'd0, 1'b1, b[22:0]};
    e = int'(a[30:23]) - int'(b[30:23]) + 127;
    if (!q[25]) begin e = e - 1; q = q << 1; end
    if (e < 1)   return {s, 31'd0};
    if (e > 254) return {s, 8'hFF, 23'd0};
    return {s, 8'(e), q[24:2]};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b,
                     output logic [31:0] res, output int lat);
    @(negedge clk);
    start = 1'b1; dividend = a; divisor = b;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    res = quotient;
  endtask

  task automatic div_case(input string tag, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    int lat;
    run(a, b, r, lat);
    check(tag, r, model(a, b));
    check({tag, " latency R4"}, 32'(lat), 32'(LAT + 1));
  endtask

  task automatic t_reset();
    check("R12 reset quotient", quotient, 32'd0);
    check("R12 reset busy", {31'd0, busy}, 32'd0);
    check("R12 reset done", {31'd0, done}, 32'd0);
  endtask

  task automatic t_literal();
    logic [31:0] r;
    int lat;
    run(32'h40C0_0000, 32'h4040_0000, r, lat);
    check("R2 6/3", r, 32'h4000_0000);
    run(32'h3F80_0000, 32'h4040_0000, r, lat);
    check("R3 1/3 truncated", r, 32'h3EAA_AAAA);
    run(32'hC0C0_0000, 32'h4040_0000, r, lat);
    check("R1 -6/3", r, 32'hC000_0000);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] r;
    int lat;
    @(negedge clk);
    start = 1'b1; dividend = 32'h4049_0FDB; divisor = 32'h402D_F854;
    @(negedge clk);
    check("R4 busy after start", {31'd0, busy}, 32'd1);
    dividend = 32'h3F80_0000; divisor = 32'h0000_0000;
    @(negedge clk);
    start = 1'b0;
    lat = 2;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    r = quotient;
    check("R5 busy start ignored", r, model(32'h4049_0FDB, 32'h402D_F854));
    check("R5 latency kept", 32'(lat), 32'(LAT + 1));
    repeat (3) @(negedge clk);
    check("R12 result held", quotient, r);
    check("R4 done one cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL R4 watchdog expired: got hang expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_literal();
    div_case("R2 1/1", 32'h3F80_0000, 32'h3F80_0000);
    div_case("R2 R3 pi/e", 32'h4049_0FDB, 32'h402D_F854);
    div_case("R1 6/-3", 32'h40C0_0000, 32'hC040_0000);
    div_case("R1 -6/-3", 32'hC0C0_0000, 32'hC040_0000);
    div_case("R6 NaN dividend", 32'h7F80_0001, 32'h3F80_0000);
    div_case("R6 NaN divisor", 32'h3F80_0000, 32'hFFC0_0000);
    div_case("R6 zero divisor", 32'h3F80_0000, 32'h0000_0000);
    div_case("R6 zero/zero", 32'h0000_0000, 32'h0000_0000);
    div_case("R6 inf/zero", 32'h7F80_0000, 32'h8000_0000);
    div_case("R7 inf dividend", 32'h7F80_0000, 32'h3F80_0000);
    div_case("R7 inf/inf", 32'hFF80_0000, 32'h7F80_0000);
    div_case("R8 inf divisor", 32'h3F80_0000, 32'h7F80_0000);
    div_case("R8 R1 neg inf divisor", 32'hBF80_0000, 32'h7F80_0000);
    div_case("R9 zero dividend", 32'h0000_0000, 32'h4000_0000);
    div_case("R9 R1 neg zero dividend", 32'h8000_0000, 32'h4000_0000);
    div_case("R9 denormal dividend", 32'h0000_0005, 32'h3F80_0000);
    div_case("R10 underflow", 32'h0080_0000, 32'h7F00_0000);
    div_case("R10 exponent 1 kept", 32'h00C0_0000, 32'h3F80_0000);
    div_case("R10 shift to 0", 32'h0080_0000, 32'h3FC0_0000);
    div_case("R11 overflow", 32'h7F00_0000, 32'h0080_0000);
    div_case("R11 exponent 254 kept", 32'h7F7F_FFFF, 32'h3F80_0000);
    div_case("R11 exponent 255", 32'h7F00_0000, 32'h3F00_0000);
    div_case("R11 R1 neg overflow", 32'hFF00_0000, 32'h0080_0000);
    t_busy_ignore();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule